// File: doc/BRIEF.md
# Standard Pause Receiver with Transmit Hold

This block watches the receive byte stream of an Ethernet MAC for standard pause control frames and, when one is accepted, stops the local transmit client from starting new frames for the requested number of pause quanta. The transmit gate never cuts a frame short. If a pause arrives while the client is sending, the block lets that frame run to its end and engages the hold at the following frame boundary. The pause timer only counts down while the hold is engaged.

The received frame is presented one byte per cycle with start, end and good markers. Two configuration bits must both be set before any pause is acted on. A quantum strobe input paces the countdown. A quantum is 512 bit times, so the number of strobes per quantum is derived from the datapath width parameter: two for a 256-bit path and one for a 512-bit path. A later pause replaces whatever count remains. A pause of zero releases the hold at once.

Top module: `pause_tx_gate`

## Requirements
- R1: A received frame causes a pause only if its first six bytes are 01 80 C2 00 00 01, bytes 12..13 are 88 08 and bytes 14..15 are 00 01. Bytes 16 (high) and 17 (low) carry the 16-bit quanta. A frame failing any of these leaves the timer unchanged.
- R2: A pause is loaded only when `cfg_rx_pause_en` and `cfg_tx_xoff_en` are both 1. This is sampled in the cycle after the frame's last byte.
- R3: While a transmit frame is in flight, `tx_hold` stays 0 and `tx_ready` stays 1 until the frame's end beat. The countdown does not advance during that time. The hold appears in the cycle after the end beat.
- R4: A received quanta value overwrites the remaining count, so the most recent pause decides the hold length.
- R5: A pause carrying quanta 0 clears the hold.
- R6: While the hold is engaged, the count drops by one per quantum, and the hold ends when it reaches zero.
- R7: One quantum is 512/DATA_W asserted cycles of `quanta_tick`. Cycles with the tick low do not advance the countdown.
- R8: While the hold is engaged, `tx_ready` is 0 and a start beat from the client is not accepted. After reset, `tx_ready` is 1 and `tx_hold` is 0.
- R9: A frame whose end beat has `rx_good` low leaves the timer unchanged.
- R10: When the transmitter is idle, `tx_hold` rises two cycles after the cycle carrying the pause frame's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a received frame |
| rx_eof | input | 1 | Last byte of a received frame |
| rx_good | input | 1 | Frame passed its checks; meaningful with rx_eof |
| rx_data | input | 8 | Received byte |
| cfg_rx_pause_en | input | 1 | Enable reaction to received pause frames |
| cfg_tx_xoff_en | input | 1 | Enable transmit suspension by pause frames |
| quanta_tick | input | 1 | Countdown strobe, one per datapath cycle |
| tx_valid | input | 1 | Client transmit beat valid |
| tx_sof | input | 1 | Client transmit start beat |
| tx_eof | input | 1 | Client transmit end beat |
| tx_ready | output | 1 | Client may present beats; low while held between frames |
| tx_hold | output | 1 | Pause hold engaged |

## Verification
The hardest case to reach is a pause that lands in the middle of a long transmit frame. The bench forks a client frame longer than the 60-byte pause frame alongside the receive stream. The load then happens mid-frame, and the bench confirms that the hold and the countdown stay idle until the end beat. A second fork holds a client start beat against an engaged hold and releases it with a zero-quanta frame. A behavioural model tracks byte queues and counts, and the bench compares against it on every cycle. This also covers override, gated ticks and rejected headers.

// File: rtl/pause_pkg.sv
`timescale 1ns/1ps
package pause_pkg;
  localparam int QUANTA_W = 16;
  localparam int HDR_LEN  = 18;
  localparam int IDX_W    = $clog2(HDR_LEN + 1);
  localparam int QHI_POS  = 16;
  localparam int QLO_POS  = 17;

  // byte positions compared against a fixed value
  function automatic logic hdr_checked(input logic [IDX_W-1:0] pos);
    return (pos < IDX_W'(6)) || ((pos >= IDX_W'(12)) && (pos < IDX_W'(16)));
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] pos);
    logic [7:0] b;
    case (pos)
      IDX_W'(0):  b = 8'h01;
      IDX_W'(1):  b = 8'h80;
      IDX_W'(2):  b = 8'hC2;
      IDX_W'(5):  b = 8'h01;
      IDX_W'(12): b = 8'h88;
      IDX_W'(13): b = 8'h08;
      IDX_W'(15): b = 8'h01;
      default:    b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/pause_rx_parser.sv
`timescale 1ns/1ps
module pause_rx_parser
  import pause_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic                rx_good,
  input  logic [7:0]          rx_data,
  output logic                evt_o,
  output logic [QUANTA_W-1:0] quanta_o
);
  logic [IDX_W-1:0]    idx_q, idx_d, pos;
  logic                match_q, match_d, match_now, byte_ok;
  logic [QUANTA_W-1:0] field_q, field_d;
  logic                evt_q, evt_d;
  logic [QUANTA_W-1:0] quanta_q, quanta_d;

  always_comb begin
    pos       = rx_sof ? '0 : idx_q;
    byte_ok   = !hdr_checked(pos) || (rx_data == hdr_byte(pos));
    match_now = (rx_sof ? 1'b1 : match_q) && byte_ok;
    idx_d     = idx_q;
    match_d   = match_q;
    field_d   = field_q;
    evt_d     = 1'b0;
    quanta_d  = quanta_q;
    if (rx_valid) begin
      idx_d   = (pos == IDX_W'(HDR_LEN)) ? pos : pos + IDX_W'(1);
      match_d = match_now;
      if (pos == IDX_W'(QHI_POS)) field_d[15:8] = rx_data;
      if (pos == IDX_W'(QLO_POS)) field_d[7:0]  = rx_data;
      if (rx_eof) begin
        evt_d    = rx_good && match_now && (pos >= IDX_W'(QLO_POS));
        quanta_d = (pos == IDX_W'(QLO_POS)) ? {field_q[15:8], rx_data} : field_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      match_q  <= 1'b0;
      field_q  <= '0;
      evt_q    <= 1'b0;
      quanta_q <= '0;
    end else begin
      idx_q    <= idx_d;
      match_q  <= match_d;
      field_q  <= field_d;
      evt_q    <= evt_d;
      quanta_q <= quanta_d;
    end
  end

  assign evt_o    = evt_q;
  assign quanta_o = quanta_q;

  AST_EVT_AFTER_GOOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(rx_valid && rx_eof && rx_good)); // R9
endmodule

// File: rtl/pause_quanta_timer.sv
`timescale 1ns/1ps
module pause_quanta_timer
  import pause_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_evt,
  input  logic [QUANTA_W-1:0] load_val,
  input  logic                enable,
  input  logic                run,
  input  logic                tick,
  output logic                active_o
);
  localparam int TPQ   = 512 / DATA_W;
  localparam int SUB_W = (TPQ > 1) ? $clog2(TPQ) : 1;

  logic                load, step;
  logic [QUANTA_W-1:0] count_q, count_d;

  assign load = load_evt && enable;

  generate
    if (TPQ == 1) begin : g_direct
      assign step = tick && run && !load;
    end else begin : g_prescale
      logic [SUB_W-1:0] sub_q, sub_d;
      always_comb begin
        sub_d = sub_q;
        step  = 1'b0;
        if (load) begin
          sub_d = '0;
        end else if (tick && run && (count_q != '0)) begin
          if (sub_q == SUB_W'(TPQ - 1)) begin
            sub_d = '0;
            step  = 1'b1;
          end else begin
            sub_d = sub_q + SUB_W'(1);
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
      end
    end
  endgenerate

  always_comb begin
    count_d = count_q;
    if (load)                          count_d = load_val;
    else if (step && (count_q != '0))  count_d = count_q - QUANTA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign active_o = (count_q != '0);

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && enable) |=> (count_q == $past(load_val))); // R4
  AST_NO_GROWTH_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && enable) |=> (count_q <= $past(count_q))); // R2
  AST_FROZEN_WHEN_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!(load_evt && enable) && !run) |=> $stable(count_q)); // R3
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(load_evt && enable) && (count_q != '0)) |=>
      ((count_q == $past(count_q)) || (count_q == $past(count_q) - QUANTA_W'(1)))); // R6
endmodule

// File: rtl/pause_tx_boundary.sv
`timescale 1ns/1ps
module pause_tx_boundary (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_req,
  input  logic tx_valid,
  input  logic tx_sof,
  input  logic tx_eof,
  output logic tx_ready,
  output logic hold_o
);
  logic in_frame_q, in_frame_d, sof_acc;

  assign tx_ready = in_frame_q || !pause_req;
  assign hold_o   = pause_req && !in_frame_q;
  assign sof_acc  = tx_valid && tx_sof && tx_ready;

  always_comb begin
    in_frame_d = in_frame_q;
    if (tx_valid && tx_eof && (in_frame_q || sof_acc)) in_frame_d = 1'b0;
    else if (sof_acc)                                   in_frame_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_frame_q <= 1'b0;
    else        in_frame_q <= in_frame_d;
  end

  AST_NO_START_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !in_frame_q) |=> !in_frame_q); // R8
endmodule

// File: rtl/pause_tx_gate.sv
`timescale 1ns/1ps
module pause_tx_gate
  import pause_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       rx_good,
  input  logic [7:0] rx_data,
  input  logic       cfg_rx_pause_en,
  input  logic       cfg_tx_xoff_en,
  input  logic       quanta_tick,
  input  logic       tx_valid,
  input  logic       tx_sof,
  input  logic       tx_eof,
  output logic       tx_ready,
  output logic       tx_hold
);
  logic                pause_evt;
  logic [QUANTA_W-1:0] pause_val;
  logic                pause_req;

  pause_rx_parser u_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_good(rx_good), .rx_data(rx_data),
    .evt_o(pause_evt), .quanta_o(pause_val));

  pause_quanta_timer #(.DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_evt(pause_evt), .load_val(pause_val),
    .enable(cfg_rx_pause_en && cfg_tx_xoff_en), .run(tx_hold),
    .tick(quanta_tick), .active_o(pause_req));

  pause_tx_boundary u_boundary (
    .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .tx_valid(tx_valid),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready), .hold_o(tx_hold));

  AST_HOLD_MEANS_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |-> !tx_ready); // R8
endmodule

// File: tb/pause_tx_gate_test.sv
`timescale 1ns/1ps
module pause_tx_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 256;
  localparam int TPQ = 512 / DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic [7:0] rx_data = 8'h00;
  logic en_rx = 1, en_xoff = 1, tick = 1;
  logic tx_valid = 0, tx_sof = 0, tx_eof = 0;
  logic tx_ready, tx_hold;
  bit   tick_toggle = 0;
  int   checks = 0, errors = 0;
  string phase = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_tx_gate #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_good(rx_good), .rx_data(rx_data),
    .cfg_rx_pause_en(en_rx), .cfg_tx_xoff_en(en_xoff), .quanta_tick(tick),
    .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_ready(tx_ready), .tx_hold(tx_hold));

  // behavioural reference
  byte unsigned rxq[$];
  int  m_cnt = 0, m_sub = 0, m_pq = 0;
  bit  m_pend = 0, m_inf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxq.delete(); m_cnt = 0; m_sub = 0; m_pq = 0; m_pend = 0; m_inf = 0;
    end else begin
      bit ld, holdo, readyo, acc, newp;
      int ldv;
      ld = m_pend && en_rx && en_xoff; ldv = m_pq;
      holdo = (m_cnt != 0) && !m_inf;
      readyo = m_inf || (m_cnt == 0);
      newp = 0;
      if (rx_valid) begin
        if (rx_sof) rxq.delete();
        rxq.push_back(rx_data);
        if (rx_eof && rx_good && rxq.size() >= 18 &&
            rxq[0] == 8'h01 && rxq[1] == 8'h80 && rxq[2] == 8'hC2 &&
            rxq[3] == 8'h00 && rxq[4] == 8'h00 && rxq[5] == 8'h01 &&
            rxq[12] == 8'h88 && rxq[13] == 8'h08 &&
            rxq[14] == 8'h00 && rxq[15] == 8'h01) begin
          newp = 1; m_pq = rxq[16] * 256 + rxq[17];
        end
      end
      if (ld) begin
        m_cnt = ldv; m_sub = 0;
      end else if (tick && holdo) begin
        m_sub++;
        if (m_sub == TPQ) begin m_sub = 0; m_cnt--; end
      end
      acc = tx_valid && tx_sof && readyo;
      if (tx_valid && tx_eof && (m_inf || acc)) m_inf = 0;
      else if (acc) m_inf = 1;
      m_pend = newp;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tx_ready, m_inf || (m_cnt == 0), phase, "tx_ready vs model");
    chk(tx_hold, (m_cnt != 0) && !m_inf, phase, "tx_hold vs model");
  end

  always @(negedge clk) if (tick_toggle) tick = ~tick;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input int q, input bit bad_da, input logic [15:0] ty,
                         input logic [15:0] op, input bit good);
    byte unsigned f[60];
    for (int i = 0; i < 60; i++) f[i] = 8'h00;
    f[0] = 8'h01; f[1] = 8'h80; f[2] = bad_da ? 8'hC3 : 8'hC2; f[5] = 8'h01;
    for (int i = 6; i < 12; i++) f[i] = byte'(8'h20 + i);
    f[12] = ty[15:8]; f[13] = ty[7:0]; f[14] = op[15:8]; f[15] = op[7:0];
    f[16] = byte'(q >> 8); f[17] = byte'(q);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == 59);
      rx_good = (i == 59) ? good : 1'b0; rx_data = f[i];
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0;
  endtask

  task automatic pause(input int q);
    send_rx(q, 0, 16'h8808, 16'h0001, 1);
  endtask

  task automatic tx_frame(input int beats);
    bit acc;
    @(negedge clk);
    tx_valid = 1; tx_sof = 1; tx_eof = (beats == 1);
    forever begin
      #1 acc = tx_ready;
      @(negedge clk);
      if (acc) break;
    end
    for (int i = 1; i < beats; i++) begin
      tx_sof = 0; tx_eof = (i == beats - 1);
      @(negedge clk);
    end
    tx_valid = 0; tx_sof = 0; tx_eof = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk(tx_ready, 1, "R8", "reset ready");
    chk(tx_hold, 0, "R8", "reset hold");

    phase = "R10"; pause(3); cyc(1);
    chk(tx_hold, 1, "R10", "hold two cycles after end byte");
    phase = "R6"; cyc(3 * TPQ + 2);
    chk(tx_hold, 0, "R6", "hold released on expiry");

    phase = "R1"; send_rx(40, 1, 16'h8808, 16'h0001, 1); cyc(3);
    chk(tx_hold, 0, "R1", "wrong address ignored");
    send_rx(40, 0, 16'h8809, 16'h0001, 1); cyc(3);
    chk(tx_hold, 0, "R1", "wrong type ignored");
    send_rx(40, 0, 16'h8808, 16'h0101, 1); cyc(3);
    chk(tx_hold, 0, "R1", "wrong opcode ignored");

    phase = "R9"; send_rx(40, 0, 16'h8808, 16'h0001, 0); cyc(3);
    chk(tx_hold, 0, "R9", "bad frame ignored");

    phase = "R2"; en_rx = 0; pause(40); cyc(3);
    chk(tx_hold, 0, "R2", "receive enable off");
    en_rx = 1; en_xoff = 0; pause(40); cyc(3);
    chk(tx_hold, 0, "R2", "xoff enable off");
    en_xoff = 1;

    phase = "R3";
    fork
      tx_frame(90);
      begin pause(200); cyc(5);
        chk(tx_hold, 0, "R3", "no hold mid-frame");
        chk(tx_ready, 1, "R3", "ready mid-frame"); end
    join
    chk(tx_hold, 1, "R3", "hold after end beat");

    phase = "R8";
    fork
      tx_frame(4);
      begin cyc(10);
        chk(tx_ready, 0, "R8", "start beat blocked");
        phase = "R5"; pause(0); cyc(1);
        chk(tx_hold, 0, "R5", "zero quanta releases"); end
    join

    phase = "R4"; pause(300); cyc(40);
    chk(tx_hold, 1, "R4", "long pause holding");
    pause(2); cyc(2 * TPQ + 3);
    chk(tx_hold, 0, "R4", "later short pause overrides");

    phase = "R7"; tick_toggle = 1; pause(4); cyc(3 * TPQ);
    chk(tx_hold, 1, "R7", "gated ticks slow the countdown");
    cyc(8 * TPQ);
    chk(tx_hold, 0, "R7", "gated countdown ends");
    tick_toggle = 0; tick = 1; cyc(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule